// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers interrupt requests from peripheral lines, picks the most urgent one and signals a processor on a single interrupt output. When the processor acknowledges, the block places an 8-bit vector for the chosen line on a data bus for one cycle and marks that line as being serviced. A later end-of-interrupt strobe ends that service. While a service is open, only a more urgent line can raise the interrupt output again, so handlers nest strictly by priority.

The top module holds one controller unit, or two when built in pair mode. In pair mode a second unit (the secondary) hangs off input 2 of the first (the primary). Its interrupt output drives that input, which gives fifteen usable lines. A request on external line 2 is steered to line 9 so that older software keeps working. When the primary grants its linked input, the secondary supplies the vector and the primary leaves the bus alone. Priority is fixed in each unit, with the lowest index the most urgent. In pair mode the system order is therefore 0, 1, 8 to 15, then 3 to 7.

Top module: `prio_irq_cascade`

## Requirements
- R1: While reset is high and after it, with no request, int_o is 0, data_oe_o is 0 and data_o is 0.
- R2: Requests are level-sensitive and sampled on the rising clock edge. A request on a primary line raises int_o at the second rising edge after it is applied. A request on a secondary line raises it at the fourth.
- R3: Among pending lines the most urgent wins the acknowledge. Inside a unit, the lower index wins. Across the pair, the order is 0, 1, 8..15, 3..7.
- R4: The rising edge that samples inta_i high loads the vector. The vector is the unit's 5-bit base as bits 7:3 and the 3-bit line index as bits 2:0. For the next cycle only, it is on data_o with data_oe_o high.
- R5: An acknowledge sets the granted line's in-service bit and drops int_o. Afterwards, a request of equal or lower priority does not raise int_o while that bit is set.
- R6: A request more urgent than every line in service raises int_o and is granted.
- R7: An eoi_i strobe clears the most urgent set in-service bit of the primary. Lower-priority requests that were waiting are then signalled.
- R8: When the primary grants input 2, the secondary drives the vector from sbase_i and its own line index. The primary drives nothing.
- R9: A request on external line 2 is treated as line 9. Its vector is {sbase_i, 3'd1}.
- R10: An acknowledge with no eligible request returns {base, 3'd7} from the acknowledged unit and sets no in-service bit.
- R11: An eoi_i that clears the primary's input-2 service also clears the most urgent in-service bit of the secondary. A new request on a secondary line is then served again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 2*LINES | Level request lines; upper half feeds the secondary |
| inta_i | input | 1 | Single-cycle processor acknowledge |
| eoi_i | input | 1 | Single-cycle end-of-interrupt strobe |
| mbase_i | input | VEC_W-log2(LINES) | Vector base of the primary |
| sbase_i | input | VEC_W-log2(LINES) | Vector base of the secondary |
| int_o | output | 1 | Interrupt request to the processor |
| data_o | output | VEC_W | Vector bus, zero when not driven |
| data_oe_o | output | 1 | High in the cycle the vector is valid |

## Verification
The bench builds the block in pair mode with eight lines per unit and an 8-bit vector. With these values all sixteen external lines can be swept one by one, and all 120 pairs of lines can be raised together. For each pair the bench computes the winner and the vector from a rank formula. Each line in the sweep uses different base values, so a vector that draws its bits from the wrong unit or base is caught. The short fixed latency makes hand-written nesting, spurious and cascade end-of-interrupt scenarios cheap to replay.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
  typedef enum logic { MODE_SINGLE = 1'b0, MODE_PAIR = 1'b1 } irq_mode_e;

  localparam int DEF_LINES     = 8;
  localparam int DEF_VEC_W     = 8;
  localparam int DEF_LINK_LINE = 2;
  localparam int DEF_REDIR     = 1;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] pend_i,
  input  logic [LINES-1:0] isr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] win_o,
  output logic             isr_any_o,
  output logic [IDX_W-1:0] isr_top_o
);
  logic [LINES-1:0] blocked;
  logic [LINES-1:0] eligible;

  assign blocked[0] = isr_i[0];
  genvar g;
  generate
    for (g = 1; g < LINES; g++) begin : g_prefix
      assign blocked[g] = blocked[g-1] | isr_i[g];
    end
  endgenerate

  assign eligible = pend_i & ~blocked;

  always_comb begin
    hit_o = 1'b0;
    win_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        hit_o = 1'b1;
        win_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    isr_any_o = 1'b0;
    isr_top_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (isr_i[i]) begin
        isr_any_o = 1'b1;
        isr_top_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int LINK_LINE = 2,
  parameter int IDX_W     = $clog2(LINES),
  parameter int BASE_W    = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  req_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  input  logic              link_en_i,
  output logic              int_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_oe_o,
  output logic              link_ack_o,
  output logic              link_eoi_o
);
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(LINES - 1);
  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(LINK_LINE);

  logic [LINES-1:0] irr_q, isr_q;
  logic             int_q, oe_q;
  logic [VEC_W-1:0] vec_q;

  logic             hit, isr_any;
  logic [IDX_W-1:0] win, isr_top;
  logic             link_win, self_drive, grant;
  logic [LINES-1:0] set_mask, eoi_mask;

  irq_prio_pick #(.LINES(LINES), .IDX_W(IDX_W)) u_pick (
    .pend_i    (irr_q),
    .isr_i     (isr_q),
    .hit_o     (hit),
    .win_o     (win),
    .isr_any_o (isr_any),
    .isr_top_o (isr_top)
  );

  assign link_win   = link_en_i && hit && (win == LINK_IDX);
  assign grant      = ack_i && hit;
  assign self_drive = ack_i && !link_win;
  assign set_mask   = grant ? (LINES'(1) << win) : '0;
  assign eoi_mask   = (eoi_i && isr_any) ? (LINES'(1) << isr_top) : '0;

  assign link_ack_o = ack_i && link_win;
  assign link_eoi_o = eoi_i && isr_any && link_en_i && (isr_top == LINK_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q <= '0;
      isr_q <= '0;
      int_q <= 1'b0;
      oe_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      irr_q <= req_i & ~set_mask;
      isr_q <= (isr_q & ~eoi_mask) | set_mask;
      int_q <= ack_i ? 1'b0 : hit;
      oe_q  <= self_drive;
      vec_q <= self_drive ? {base_i, (hit ? win : SPUR_IDX)} : '0;
    end
  end

  assign int_o    = int_q;
  assign vec_o    = vec_q;
  assign vec_oe_o = oe_q;

  // R5: in-service bits appear only through an acknowledge
  p_isr_set_by_ack_r5: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> ((isr_q & ~$past(isr_q)) == '0));

  // R5: interrupt output falls after an acknowledge
  p_int_drop_ack_r5: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !int_o);

  // R4: vector is driven only in the cycle after an acknowledge
  p_oe_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> !vec_oe_o);

  // R6: a grant is always more urgent than every open service
  p_preempt_higher_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && hit && !eoi_i) |=>
      (($past(isr_q) == '0) || ((isr_q & ~$past(isr_q)) < $past(isr_q))));

  // R7: an end-of-interrupt removes exactly one open service
  p_eoi_clears_one_r7: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !ack_i && (isr_q != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/prio_irq_cascade.sv
module prio_irq_cascade
  import irq_cfg_pkg::*;
#(
  parameter irq_mode_e MODE      = MODE_PAIR,
  parameter int        LINES     = DEF_LINES,
  parameter int        VEC_W     = DEF_VEC_W,
  parameter int        LINK_LINE = DEF_LINK_LINE,
  parameter int        REDIR     = DEF_REDIR
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [2*LINES-1:0]               irq_i,
  input  logic                             inta_i,
  input  logic                             eoi_i,
  input  logic [VEC_W-$clog2(LINES)-1:0]   mbase_i,
  input  logic [VEC_W-$clog2(LINES)-1:0]   sbase_i,
  output logic                             int_o,
  output logic [VEC_W-1:0]                 data_o,
  output logic                             data_oe_o
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int BASE_W = VEC_W - IDX_W;

  logic [LINES-1:0] m_req;
  logic             m_int, m_oe, m_link_ack, m_link_eoi;
  logic [VEC_W-1:0] m_vec;
  logic             s_int, s_oe;
  logic [VEC_W-1:0] s_vec;
  logic             link_en;

  generate
    if (MODE == MODE_PAIR) begin : g_pair
      logic [LINES-1:0] s_req;
      logic             s_link_ack_unused, s_link_eoi_unused;

      always_comb begin
        s_req        = irq_i[2*LINES-1:LINES];
        s_req[REDIR] = s_req[REDIR] | irq_i[LINK_LINE];
      end

      irq_unit #(.LINES(LINES), .VEC_W(VEC_W), .LINK_LINE(LINK_LINE),
                 .IDX_W(IDX_W), .BASE_W(BASE_W)) u_sec (
        .clk        (clk),
        .rst        (rst),
        .req_i      (s_req),
        .base_i     (sbase_i),
        .ack_i      (m_link_ack),
        .eoi_i      (m_link_eoi),
        .link_en_i  (1'b0),
        .int_o      (s_int),
        .vec_o      (s_vec),
        .vec_oe_o   (s_oe),
        .link_ack_o (s_link_ack_unused),
        .link_eoi_o (s_link_eoi_unused)
      );

      always_comb begin
        m_req            = irq_i[LINES-1:0];
        m_req[LINK_LINE] = s_int;
      end
      assign link_en = 1'b1;
    end else begin : g_single
      assign s_int   = 1'b0;
      assign s_oe    = 1'b0;
      assign s_vec   = '0;
      assign m_req   = irq_i[LINES-1:0];
      assign link_en = 1'b0;
    end
  endgenerate

  irq_unit #(.LINES(LINES), .VEC_W(VEC_W), .LINK_LINE(LINK_LINE),
             .IDX_W(IDX_W), .BASE_W(BASE_W)) u_pri (
    .clk        (clk),
    .rst        (rst),
    .req_i      (m_req),
    .base_i     (mbase_i),
    .ack_i      (inta_i),
    .eoi_i      (eoi_i),
    .link_en_i  (link_en),
    .int_o      (m_int),
    .vec_o      (m_vec),
    .vec_oe_o   (m_oe),
    .link_ack_o (m_link_ack),
    .link_eoi_o (m_link_eoi)
  );

  assign int_o     = m_int;
  assign data_o    = m_vec | s_vec;
  assign data_oe_o = m_oe | s_oe;

  // R8: the two units never drive the vector bus together
  p_single_driver_r8: assert property (@(posedge clk) disable iff (rst)
    !(m_oe && s_oe));

  // R4: bus stays zero whenever it is not driven
  p_bus_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> (data_o == '0));
endmodule

// File: tb/prio_irq_cascade_tb.sv
module prio_irq_cascade_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] irq;
  logic        inta, eoi;
  logic [4:0]  mbase, sbase;
  logic        int_o, data_oe;
  logic [7:0]  data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_cascade u_dut (
    .clk(clk), .rst(rst), .irq_i(irq), .inta_i(inta), .eoi_i(eoi),
    .mbase_i(mbase), .sbase_i(sbase), .int_o(int_o),
    .data_o(data), .data_oe_o(data_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(output logic [7:0] v, output logic oe, output logic iv);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    v = data; oe = data_oe; iv = int_o;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  function automatic logic [7:0] exp_vec(input int l);
    if (l == 2)     return {sbase, 3'd1};
    else if (l < 8) return {mbase, 3'(l)};
    else            return {sbase, 3'(l - 8)};
  endfunction

  function automatic int rank(input int l);
    int e;
    e = (l == 2) ? 9 : l;
    if (e < 2)       return e;
    else if (e >= 8) return e - 6;
    else             return e + 7;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe, iv;
    rst = 1'b1; irq = '0; inta = 1'b0; eoi = 1'b0;
    mbase = 5'h04; sbase = 5'h0D;
    cyc(3);
    chk(int_o == 1'b0, "R1 int in reset", int_o, 0);
    chk(data_oe == 1'b0, "R1 oe in reset", data_oe, 0);
    chk(data == 8'h00, "R1 data in reset", data, 0);
    rst = 1'b0;
    cyc(4);
    chk(int_o == 1'b0, "R1 int idle", int_o, 0);

    // R2 primary latency, R4 vector, R5 nesting
    irq[5] = 1'b1;
    cyc(1); chk(int_o == 1'b0, "R2 primary early", int_o, 0);
    cyc(1); chk(int_o == 1'b1, "R2 primary on time", int_o, 1);
    do_ack(v, oe, iv);
    chk(v == exp_vec(5), "R4 vector line 5", v, exp_vec(5));
    chk(oe == 1'b1, "R4 oe high", oe, 1);
    chk(iv == 1'b0, "R5 int drops on ack", iv, 0);
    cyc(1); chk(data_oe == 1'b0, "R4 oe one cycle", data_oe, 0);
    cyc(3); chk(int_o == 1'b0, "R5 equal priority waits", int_o, 0);
    irq[6] = 1'b1;
    cyc(3); chk(int_o == 1'b0, "R5 lower priority waits", int_o, 0);
    irq[3] = 1'b1;
    cyc(2); chk(int_o == 1'b1, "R6 higher preempts", int_o, 1);
    do_ack(v, oe, iv);
    chk(v == exp_vec(3), "R6 preempt vector", v, exp_vec(3));
    irq[3] = 1'b0; irq[5] = 1'b0;
    do_eoi();
    cyc(3); chk(int_o == 1'b0, "R7 inner eoi keeps outer", int_o, 0);
    do_eoi();
    cyc(3); chk(int_o == 1'b1, "R7 waiting line released", int_o, 1);
    do_ack(v, oe, iv);
    chk(v == exp_vec(6), "R7 released vector", v, exp_vec(6));
    irq[6] = 1'b0;
    do_eoi();
    cyc(3);

    // R2 secondary latency, R8 cascade vector, R6 across the pair
    irq[11] = 1'b1;
    cyc(3); chk(int_o == 1'b0, "R2 secondary early", int_o, 0);
    cyc(1); chk(int_o == 1'b1, "R2 secondary on time", int_o, 1);
    do_ack(v, oe, iv);
    chk(v == exp_vec(11), "R8 secondary vector", v, exp_vec(11));
    chk(oe == 1'b1, "R8 secondary drives", oe, 1);
    irq[0] = 1'b1;
    cyc(2); chk(int_o == 1'b1, "R6 line 0 over secondary", int_o, 1);
    do_ack(v, oe, iv);
    chk(v == exp_vec(0), "R6 line 0 vector", v, exp_vec(0));
    irq[0] = 1'b0; irq[11] = 1'b0;
    do_eoi(); do_eoi();
    cyc(6); chk(int_o == 1'b0, "R7 all closed", int_o, 0);

    // R11 cascade end-of-interrupt
    irq[9] = 1'b1;
    cyc(5); do_ack(v, oe, iv);
    chk(v == exp_vec(9), "R11 first line 9", v, exp_vec(9));
    irq[9] = 1'b0; do_eoi(); cyc(3);
    irq[9] = 1'b1;
    cyc(5); chk(int_o == 1'b1, "R11 secondary served again", int_o, 1);
    do_ack(v, oe, iv);
    chk(v == exp_vec(9), "R11 second line 9", v, exp_vec(9));
    irq[9] = 1'b0; do_eoi(); cyc(6);

    // R9 redirection
    irq[2] = 1'b1;
    cyc(5); chk(int_o == 1'b1, "R9 line 2 raises int", int_o, 1);
    do_ack(v, oe, iv);
    chk(v == {sbase, 3'd1}, "R9 line 2 as line 9", v, {sbase, 3'd1});
    irq[2] = 1'b0; do_eoi(); cyc(6);

    // R10 spurious acknowledge
    irq[4] = 1'b1;
    cyc(2); irq[4] = 1'b0;
    cyc(1); do_ack(v, oe, iv);
    chk(v == {mbase, 3'd7}, "R10 spurious vector", v, {mbase, 3'd7});
    chk(oe == 1'b1, "R10 spurious drives", oe, 1);
    cyc(2); chk(int_o == 1'b0, "R10 idle after spurious", int_o, 0);
    irq[7] = 1'b1;
    cyc(2); chk(int_o == 1'b1, "R10 no service left open", int_o, 1);
    do_ack(v, oe, iv);
    chk(v == exp_vec(7), "R10 line 7 real", v, exp_vec(7));
    irq[7] = 1'b0; do_eoi(); cyc(6);

    // R3/R4 single-line sweep with varying bases
    for (int l = 0; l < 16; l++) begin
      mbase = 5'(l + 1); sbase = 5'(31 - l);
      irq[l] = 1'b1;
      cyc(6); chk(int_o == 1'b1, "R3 sweep int", int_o, 1);
      do_ack(v, oe, iv);
      chk(v == exp_vec(l), "R4 sweep vector", v, exp_vec(l));
      chk(oe == 1'b1, "R4 sweep oe", oe, 1);
      irq = '0; do_eoi(); cyc(6);
    end

    // R3 all pairs
    mbase = 5'h11; sbase = 5'h0A;
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        int fst, snd;
        fst = (rank(a) <= rank(b)) ? a : b;
        snd = (fst == a) ? b : a;
        irq = '0; irq[a] = 1'b1; irq[b] = 1'b1;
        cyc(6); do_ack(v, oe, iv);
        chk(v == exp_vec(fst), "R3 pair winner", v, exp_vec(fst));
        if (rank(a) == rank(b)) begin
          irq = '0; do_eoi(); cyc(6);
        end else begin
          irq[fst] = 1'b0; do_eoi(); cyc(6);
          chk(int_o == 1'b1, "R7 pair loser signalled", int_o, 1);
          do_ack(v, oe, iv);
          chk(v == exp_vec(snd), "R3 pair loser vector", v, exp_vec(snd));
          irq = '0; do_eoi(); cyc(6);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule